// File: doc/BRIEF.md
# Single-Wire Bus ROM Command Layer

This block is the network-layer sequencer of a single-wire bus slave. It sits between a bit layer and a function layer. The bit layer detects bus resets and time slots. After every bus reset the block collects an 8-bit ROM command, least significant bit first. It then carries out the selected addressing action against a 64-bit device identity that is fixed by a parameter. The identity holds a family byte in bits 7:0, a 48-bit serial number in bits 55:8 and a check byte in bits 63:56. It is always moved least significant bit first.

The block keeps two flags: a resume flag and an overdrive flag. When addressing succeeds, it holds a grant to the function layer until the next bus reset. When addressing fails, or the command code is unknown, it ignores every slot until the next bus reset. The bit layer reports each time slot with one pulse on `slot_i`, which carries the bit the master left on the line. When `tx_active_o` is high, the current slot is a read slot and the bit layer drives `tx_bit_o` onto the line.

Top module: `owrom_netlayer`

## Requirements
- R1: After code 33h, the next 64 slots are read slots. They present the identity bits in order, bit 0 first. After the 64th slot, `grant_o` rises.
- R2: Code 55h receives 64 slot bits. `grant_o` rises after the 64th slot only if every bit equals the identity bit at the same position.
- R3: In an address match, one differing bit sends the block idle. While idle, `grant_o` and `tx_active_o` stay low and further slots have no effect until a bus reset.
- R4: Code F0h runs 64 slot triplets. Each triplet is a read slot with the identity bit, a read slot with its complement, then a write slot. After the last triplet matches, `grant_o` rises.
- R5: In a search, a write slot whose bit differs from the identity bit sends the block idle.
- R6: Code CCh raises `grant_o` right after the command byte.
- R7: The resume flag is 0 after power-up reset. Codes 33h, 55h, F0h, CCh, 3Ch and 69h clear it. A successful 55h, F0h or 69h sets it. Code A5h grants only if the flag is 1 and leaves it unchanged. Otherwise A5h goes idle.
- R8: Code 3Ch sets `od_o` and raises `grant_o` right after the command byte. A bus reset with `bus_rst_long_i` = 1 clears `od_o`. A bus reset with `bus_rst_long_i` = 0 leaves it unchanged.
- R9: Code 69h sets `od_o` right after the command byte, then runs as R2. `od_o` stays 1 even if the match fails.
- R10: Any other command code sends the block idle and leaves the resume flag unchanged.
- R11: A bus reset at any time clears `grant_o`, drops any partly received command, and restarts command reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_rst_i | input | 1 | One-cycle pulse: bus reset and presence completed |
| bus_rst_long_i | input | 1 | Qualifies `bus_rst_i`: the reset was long enough to leave overdrive |
| slot_i | input | 1 | One-cycle pulse per completed time slot |
| slot_bit_i | input | 1 | Bit written by the master in that slot |
| tx_active_o | output | 1 | The coming slot is a read slot driven by this device |
| tx_bit_o | output | 1 | Bit to present in the coming read slot |
| grant_o | output | 1 | Function layer access granted |
| od_o | output | 1 | Overdrive speed selected |

## Verification
The resume flag is hardest to observe, because it has no port and can only be seen through the outcome of a later A5h command. The stimulus therefore builds chains of bus resets and commands. In each chain, a successful match, a failed match, a skip or an unknown code comes first, and A5h comes after one or more resets. The same approach checks that overdrive survives a failed 69h and a short reset, and that a long reset clears it.

// File: rtl/owrom_pkg.sv
package owrom_pkg;
  typedef enum logic [2:0] {
    ST_CMD, ST_READ, ST_MATCH, ST_SEARCH, ST_GRANT, ST_IDLE
  } net_state_e;

  localparam logic [7:0] CMD_READ     = 8'h33;
  localparam logic [7:0] CMD_MATCH    = 8'h55;
  localparam logic [7:0] CMD_SEARCH   = 8'hF0;
  localparam logic [7:0] CMD_SKIP     = 8'hCC;
  localparam logic [7:0] CMD_RESUME   = 8'hA5;
  localparam logic [7:0] CMD_OD_SKIP  = 8'h3C;
  localparam logic [7:0] CMD_OD_MATCH = 8'h69;
endpackage

// File: rtl/owrom_cmd_rx.sv
// Collects a command byte, least significant bit first.
module owrom_cmd_rx #(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [CMD_W-1:0] cmd_next_o,
  output logic             last_o
);
  localparam int CW = $clog2(CMD_W);
  localparam logic [CW-1:0] LAST = CW'(CMD_W - 1);

  logic [CMD_W-1:0] sh_q;
  logic [CW-1:0]    cnt_q, cnt_d;

  assign cmd_next_o = {bit_i, sh_q[CMD_W-1:1]};
  assign last_o     = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (en_i) sh_q <= cmd_next_o;
    end
  end
endmodule

// File: rtl/owrom_id_seq.sv
// Walks the identity bits from bit 0 upward.
module owrom_id_seq #(
  parameter int          ID_W     = 64,
  parameter logic [63:0] ID_VALUE = 64'h0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic step_i,
  output logic id_bit_o,
  output logic last_o
);
  localparam int IW = $clog2(ID_W);
  localparam logic [IW-1:0] LAST = IW'(ID_W - 1);

  logic [IW-1:0] idx_q, idx_d;

  assign id_bit_o = ID_VALUE[idx_q];
  assign last_o   = (idx_q == LAST);

  always_comb begin
    idx_d = idx_q;
    if (clr_i)       idx_d = '0;
    else if (step_i) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end
endmodule

// File: rtl/owrom_netlayer.sv
module owrom_netlayer #(
  parameter int          ID_W     = 64,
  parameter logic [63:0] ID_VALUE = 64'hA15E_3C9D_4472_B02B,
  parameter int          CMD_W    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_rst_i,
  input  logic bus_rst_long_i,
  input  logic slot_i,
  input  logic slot_bit_i,
  output logic tx_active_o,
  output logic tx_bit_o,
  output logic grant_o,
  output logic od_o
);
  import owrom_pkg::*;

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  net_state_e       st_q, st_d;
  logic             rc_q, rc_d, od_q, od_d, gr_q, gr_d;
  logic [1:0]       ph_q, ph_d;
  logic             cmd_clr, cmd_en, cmd_last;
  logic [CMD_W-1:0] cmd_next;
  logic             idx_clr, idx_step, idx_last, id_bit;

  owrom_cmd_rx #(.CMD_W(CMD_W)) u_cmd (
    .clk(clk), .rst_n(rst_s_n), .clr_i(cmd_clr), .en_i(cmd_en),
    .bit_i(slot_bit_i), .cmd_next_o(cmd_next), .last_o(cmd_last)
  );

  owrom_id_seq #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_id (
    .clk(clk), .rst_n(rst_s_n), .clr_i(idx_clr), .step_i(idx_step),
    .id_bit_o(id_bit), .last_o(idx_last)
  );

  always_comb begin
    st_d = st_q; rc_d = rc_q; od_d = od_q; gr_d = gr_q; ph_d = ph_q;
    cmd_clr = 1'b0; cmd_en = 1'b0; idx_clr = 1'b0; idx_step = 1'b0;
    if (bus_rst_i) begin
      st_d = ST_CMD; gr_d = 1'b0; ph_d = 2'd0;
      cmd_clr = 1'b1; idx_clr = 1'b1;
      if (bus_rst_long_i) od_d = 1'b0;
    end else if (slot_i) begin
      unique case (st_q)
        ST_CMD: begin
          cmd_en = 1'b1;
          if (cmd_last) begin
            cmd_clr = 1'b1; idx_clr = 1'b1; ph_d = 2'd0;
            case (cmd_next)
              CMD_READ:     begin rc_d = 1'b0; st_d = ST_READ; end
              CMD_MATCH:    begin rc_d = 1'b0; st_d = ST_MATCH; end
              CMD_SEARCH:   begin rc_d = 1'b0; st_d = ST_SEARCH; end
              CMD_SKIP:     begin rc_d = 1'b0; st_d = ST_GRANT; gr_d = 1'b1; end
              CMD_OD_SKIP:  begin rc_d = 1'b0; od_d = 1'b1; st_d = ST_GRANT; gr_d = 1'b1; end
              CMD_OD_MATCH: begin rc_d = 1'b0; od_d = 1'b1; st_d = ST_MATCH; end
              CMD_RESUME: begin
                if (rc_q) begin st_d = ST_GRANT; gr_d = 1'b1; end
                else        st_d = ST_IDLE;
              end
              default: st_d = ST_IDLE;
            endcase
          end
        end
        ST_READ: begin
          if (idx_last) begin st_d = ST_GRANT; gr_d = 1'b1; end
          else          idx_step = 1'b1;
        end
        ST_MATCH: begin
          if (slot_bit_i != id_bit) st_d = ST_IDLE;
          else if (idx_last) begin st_d = ST_GRANT; gr_d = 1'b1; rc_d = 1'b1; end
          else idx_step = 1'b1;
        end
        ST_SEARCH: begin
          if (ph_q != 2'd2) ph_d = ph_q + 2'd1;
          else begin
            ph_d = 2'd0;
            if (slot_bit_i != id_bit) st_d = ST_IDLE;
            else if (idx_last) begin st_d = ST_GRANT; gr_d = 1'b1; rc_d = 1'b1; end
            else idx_step = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q <= ST_CMD;
      rc_q <= 1'b0;
      od_q <= 1'b0;
      gr_q <= 1'b0;
      ph_q <= 2'd0;
    end else begin
      st_q <= st_d;
      rc_q <= rc_d;
      od_q <= od_d;
      gr_q <= gr_d;
      ph_q <= ph_d;
    end
  end

  assign tx_active_o = (st_q == ST_READ) || ((st_q == ST_SEARCH) && (ph_q != 2'd2));
  assign tx_bit_o    = ((st_q == ST_SEARCH) && (ph_q == 2'd1)) ? ~id_bit : id_bit;
  assign grant_o     = gr_q;
  assign od_o        = od_q;
endmodule

// File: rtl/owrom_netlayer_chk.sv
module owrom_netlayer_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_rst_i,
  input logic bus_rst_long_i,
  input logic slot_i,
  input logic tx_active_o,
  input logic grant_o,
  input logic od_o
);
  // R11
  a_r11_reset_drops_grant: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i |=> !grant_o);
  // R8
  a_r8_long_reset_clears_od: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst_i && bus_rst_long_i) |=> !od_o);
  // R9
  a_r9_od_falls_only_on_long_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (od_o && !(bus_rst_i && bus_rst_long_i)) |=> od_o);
  // R1
  a_r1_no_tx_while_granted: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> !tx_active_o);
  // R6
  a_r6_grant_needs_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_o && !slot_i) |=> !grant_o);
  // R11
  a_r11_grant_held_until_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o && !bus_rst_i) |=> grant_o);
endmodule

bind owrom_netlayer owrom_netlayer_chk u_chk (
  .clk(clk), .rst_n(rst_s_n), .bus_rst_i(bus_rst_i), .bus_rst_long_i(bus_rst_long_i),
  .slot_i(slot_i), .tx_active_o(tx_active_o), .grant_o(grant_o), .od_o(od_o)
);

// File: tb/owrom_netlayer_tb.sv
module owrom_netlayer_tb;
  localparam logic [63:0] ID = 64'hA15E_3C9D_4472_B02B;

  logic clk = 1'b0;
  logic rst_n, bus_rst_i, bus_rst_long_i, slot_i, slot_bit_i;
  logic tx_active_o, tx_bit_o, grant_o, od_o;
  int   n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  owrom_netlayer #(.ID_VALUE(ID)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_rst_i(bus_rst_i), .bus_rst_long_i(bus_rst_long_i),
    .slot_i(slot_i), .slot_bit_i(slot_bit_i), .tx_active_o(tx_active_o),
    .tx_bit_o(tx_bit_o), .grant_o(grant_o), .od_o(od_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_reset(input logic lng);
    @(negedge clk); bus_rst_i = 1'b1; bus_rst_long_i = lng;
    @(negedge clk); bus_rst_i = 1'b0; bus_rst_long_i = 1'b0;
  endtask

  task automatic wr_bit(input logic b);
    @(negedge clk); slot_i = 1'b1; slot_bit_i = b;
    @(negedge clk); slot_i = 1'b0; slot_bit_i = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) wr_bit(v[i]);
  endtask

  task automatic wr_id(input logic [63:0] v);
    for (int i = 0; i < 64; i++) wr_bit(v[i]);
  endtask

  // read slot: sample what the device presents, then close the slot
  task automatic rd_bit(output logic b, output logic act);
    b = tx_bit_o; act = tx_active_o;
    wr_bit(1'b1);
  endtask

  task automatic t_reset_state;
    check("R7 reset grant", grant_o, 0);
    check("R8 reset od", od_o, 0);
    check("R1 reset tx_active", tx_active_o, 0);
  endtask

  task automatic t_read;
    logic [63:0] got; logic b, a; logic all_act;
    all_act = 1'b1;
    bus_reset(1'b1); wr_byte(8'h33);
    for (int i = 0; i < 64; i++) begin rd_bit(b, a); got[i] = b; all_act &= a; end
    check("R1 read id", got, ID);
    check("R1 read slots active", all_act, 1);
    check("R1 read grant", grant_o, 1);
  endtask

  task automatic t_match_ok;
    bus_reset(1'b1); wr_byte(8'h55); wr_id(ID);
    check("R2 match grant", grant_o, 1);
    check("R2 match od", od_o, 0);
  endtask

  task automatic t_match_bad;
    bus_reset(1'b1); wr_byte(8'h55); wr_id(ID ^ 64'h1 << 37);
    check("R3 mismatch no grant", grant_o, 0);
    wr_byte(8'hCC);
    check("R3 idle ignores skip", grant_o, 0);
    check("R3 idle no tx", tx_active_o, 0);
  endtask

  task automatic t_search(input int bad_at);
    logic b0, b1, a0, a1; logic ok;
    ok = 1'b1;
    bus_reset(1'b1); wr_byte(8'hF0);
    for (int i = 0; i < 64; i++) begin
      if (bad_at >= 0 && i > bad_at) break;
      rd_bit(b0, a0); rd_bit(b1, a1);
      if (b0 !== ID[i] || b1 !== ~ID[i] || !a0 || !a1) ok = 1'b0;
      wr_bit((i == bad_at) ? ~ID[i] : ID[i]);
    end
    if (bad_at < 0) begin
      check("R4 search triplets", ok, 1);
      check("R4 search grant", grant_o, 1);
    end else begin
      check("R5 search drop grant", grant_o, 0);
      check("R5 search drop tx", tx_active_o, 0);
    end
  endtask

  task automatic t_skip;
    bus_reset(1'b1); wr_byte(8'hCC);
    check("R6 skip grant", grant_o, 1);
  endtask

  task automatic t_resume;
    bus_reset(1'b1); wr_byte(8'h55); wr_id(ID);
    bus_reset(1'b1); wr_byte(8'hA5);
    check("R7 resume after match", grant_o, 1);
    bus_reset(1'b1); wr_byte(8'hA5);
    check("R7 resume repeat", grant_o, 1);
    bus_reset(1'b1); wr_byte(8'h5A);              // unknown code
    check("R10 unknown idle", grant_o, 0);
    bus_reset(1'b1); wr_byte(8'hA5);
    check("R10 unknown keeps rc", grant_o, 1);
    bus_reset(1'b1); wr_byte(8'hCC);
    bus_reset(1'b1); wr_byte(8'hA5);
    check("R7 skip clears rc", grant_o, 0);
    bus_reset(1'b1); wr_byte(8'hF0);
    for (int i = 0; i < 64; i++) begin wr_bit(1'b1); wr_bit(1'b1); wr_bit(ID[i]); end
    bus_reset(1'b1); wr_byte(8'hA5);
    check("R7 search sets rc", grant_o, 1);
    bus_reset(1'b1); wr_byte(8'h55); wr_id(~ID);
    bus_reset(1'b1); wr_byte(8'hA5);
    check("R7 failed match clears rc", grant_o, 0);
  endtask

  task automatic t_overdrive;
    bus_reset(1'b1); wr_byte(8'h3C);
    check("R8 od skip od", od_o, 1);
    check("R8 od skip grant", grant_o, 1);
    bus_reset(1'b0);
    check("R8 short reset keeps od", od_o, 1);
    bus_reset(1'b1);
    check("R8 long reset clears od", od_o, 0);
    wr_byte(8'h69);
    check("R9 od match sets od", od_o, 1);
    wr_id(ID ^ 64'h8000_0000_0000_0000);
    check("R9 od match fail grant", grant_o, 0);
    check("R9 od kept after fail", od_o, 1);
    bus_reset(1'b0); wr_byte(8'h69); wr_id(ID);
    check("R9 od match grant", grant_o, 1);
    bus_reset(1'b0); wr_byte(8'hA5);
    check("R7 od match sets rc", grant_o, 1);
    bus_reset(1'b1);
  endtask

  task automatic t_abort;
    bus_reset(1'b1); wr_byte(8'hCC);
    bus_reset(1'b1);
    check("R11 reset clears grant", grant_o, 0);
    for (int i = 0; i < 4; i++) wr_bit(1'b1);
    bus_reset(1'b1); wr_byte(8'hCC);
    check("R11 partial cmd dropped", grant_o, 1);
    bus_reset(1'b1); wr_byte(8'h33); wr_bit(1'b1); wr_bit(1'b1);
    bus_reset(1'b1);
    check("R11 reset ends read tx", tx_active_o, 0);
    wr_byte(8'hCC);
    check("R11 command after abort", grant_o, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog R11 actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_rst_i = 1'b0; bus_rst_long_i = 1'b0; slot_i = 1'b0; slot_bit_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_read();
    t_match_ok();
    t_match_bad();
    t_search(-1);
    t_search(5);
    t_skip();
    t_resume();
    t_overdrive();
    t_abort();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule